// File: doc/BRIEF.md
# HDLC Receive FIFO and Event Generator

This block sits after an HDLC receive deframer and before a host processor. The deframer hands it one received byte per strobe, along with a frame-start strobe and an end-of-frame strobe. The frame-start strobe is either the opening flag, in transparent operation, or an address match, when address recognition is on. The block writes the bytes of the open frame into a 64-entry byte FIFO. It raises four sticky interrupt status bits: early frame start, pool full, end of message and data overflow. When a frame ends it latches a byte count and a status byte for that frame.

The host works through a small read port. A read is a single cycle, with `rd_en` high and a register address on `rd_addr`. `rd_data` shows the addressed value combinationally during that cycle, and the side effect happens at the clock edge. A read of the data register pops the FIFO. A read of the interrupt register clears it. An overflow does not end the frame. Bytes that find the FIFO full are dropped and counted, and storing starts again as soon as the host frees a slot.

Top module: `hdlc_rx_event_gen`

## Requirements
- R1: After reset, all interrupt bits are 0, the FIFO is empty (the data register reads 0), and the status, address and count registers read 0.
- R2: A byte strobed while a frame is open is stored in the FIFO. Data register reads return stored bytes in arrival order, one per read. A read of an empty FIFO returns 0 and changes nothing. A byte strobed while no frame is open is ignored.
- R3: When `mode_addr`=1, only `rx_addr_hit` opens a frame. When `mode_addr`=0, only `rx_flag_start` opens a frame. The other strobe is ignored. A new start restarts all per-frame counts.
- R4: Interrupt bit 3 (frame start) sets at the edge that takes the second byte after a valid start, and not at the first. From that edge on, register 3 holds the first byte of the frame.
- R5: Interrupt bit 0 (pool full) sets at the edge that stores the 32nd byte of the frame, and again on every further 32 bytes stored in the same frame.
- R6: A frame byte that arrives while the FIFO holds 64 bytes is dropped, and interrupt bit 2 (overflow) sets at that same edge. Fullness is judged before any pop in the same cycle.
- R7: After an overflow the frame stays open. The next byte after a pop is stored, and the count keeps including the dropped bytes.
- R8: `rx_end` in an open frame sets interrupt bit 1 (end of message) and closes the frame. It also latches two values. The first is the frame's received byte count, including dropped bytes, read as registers 4 (bits 7:0) and 5 (bits 15:8). The second is a status byte in register 2, where bit 0 = overflow in that frame and bit 1 = frame opened in address mode. A byte on the same cycle as `rx_end` belongs to the frame.
- R9: Register 2 changes only at an end of frame. An overflow in a later, still-open frame sets interrupt bit 2 but leaves register 2 as it was.
- R10: A read of register 1 returns the interrupt bits {start, overflow, end, pool} in bits 3:0 and clears them at the edge. A bit set at that same edge stays set.
- R11: Register addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_addr | input | 1 | 1: address recognition, 0: transparent |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_flag_start | input | 1 | Opening flag seen (transparent start) |
| rx_addr_hit | input | 1 | Address matched (address-mode start) |
| rx_end | input | 1 | End of frame strobe |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Host register address |
| rd_data | output | 8 | Read data for the addressed register |
| irq_stat | output | 4 | Current interrupt bits {start, overflow, end, pool} |

## Verification
Directed frames cover four cases:
- Short frames of one and two bytes separate the second-byte timing of the start event from the first-byte timing.
- Frames of exactly 32 and 64 stored bytes, and one longer frame, show that the pool event re-arms.
- A frame longer than the FIFO depth, with no draining, shows the drop point, and a single pop then shows that reception resumes.
- A status read on the same cycle as an event shows whether the set or the clear wins.

Seeded random frames in both start modes then mix lengths from 0 to 90 bytes with interleaved reads to all addresses. This exercises overflow in one frame while an earlier frame's latched status is still pending.

// File: rtl/hrx_pkg.sv
package hrx_pkg;
  localparam int unsigned RA_DATA = 0;
  localparam int unsigned RA_IRQ  = 1;
  localparam int unsigned RA_STAT = 2;
  localparam int unsigned RA_ADDR = 3;
  localparam int unsigned RA_CNTL = 4;
  localparam int unsigned RA_CNTH = 5;

  localparam int unsigned START_DELAY = 2;

  typedef struct packed {
    logic rfs;
    logic rdo;
    logic rme;
    logic rpf;
  } irq_t;

  // frame-start event is due when the running byte count reaches the delay
  function automatic logic start_due(input logic [15:0] n_after);
    return n_after == 16'(START_DELAY);
  endfunction

  // pool event when the fill before this store is the last slot of a pool
  function automatic logic pool_wrap(input int unsigned fill, input int unsigned pool);
    return fill == pool - 1;
  endfunction

  function automatic logic [7:0] stat_byte(input logic addr_frame, input logic ovf);
    return {6'b0, addr_frame, ovf};
  endfunction
endpackage

// File: rtl/hrx_fifo.sv
module hrx_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          do_push, do_pop;

  assign full    = fill == CW'(DEPTH);
  assign empty   = fill == '0;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R6
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty); // R2
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH)); // R6
endmodule

// File: rtl/hrx_frame_track.sv
module hrx_frame_track
  import hrx_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned POOL  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_addr,
  input  logic             start_ok,
  input  logic             byte_in,
  input  logic             eof_in,
  input  logic [7:0]       din,
  input  logic             fifo_full,
  output logic             push,
  output logic             ev_rfs,
  output logic             ev_rpf,
  output logic             ev_rme,
  output logic             ev_rdo,
  output logic [7:0]       addr_byte,
  output logic [7:0]       end_stat,
  output logic [CNT_W-1:0] end_cnt
);
  localparam int unsigned PW = (POOL > 1) ? $clog2(POOL) : 1;

  logic             in_frame_q, ovf_q, afr_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    pool_q;

  logic             frame_eff, take, ovf_nx, afr_base, ovf_base;
  logic [CNT_W-1:0] cnt_base, cnt_nx;
  logic [PW-1:0]    pool_base, pool_nx;

  always_comb begin
    frame_eff = start_ok || in_frame_q;
    cnt_base  = start_ok ? '0 : cnt_q;
    pool_base = start_ok ? '0 : pool_q;
    ovf_base  = start_ok ? 1'b0 : ovf_q;
    afr_base  = start_ok ? mode_addr : afr_q;
    take      = byte_in && frame_eff;
    cnt_nx    = take ? cnt_base + 1'b1 : cnt_base;
    push      = take && !fifo_full;
    ev_rdo    = take && fifo_full;
    ev_rfs    = take && start_due(16'(cnt_nx));
    ev_rpf    = push && pool_wrap(32'(pool_base), POOL);
    if (!push)       pool_nx = pool_base;
    else if (ev_rpf) pool_nx = '0;
    else             pool_nx = pool_base + 1'b1;
    ovf_nx    = ovf_base || ev_rdo;
    ev_rme    = eof_in && frame_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      pool_q     <= '0;
      ovf_q      <= 1'b0;
      afr_q      <= 1'b0;
      addr_byte  <= '0;
      end_stat   <= '0;
      end_cnt    <= '0;
    end else begin
      in_frame_q <= frame_eff && !ev_rme;
      cnt_q      <= cnt_nx;
      pool_q     <= pool_nx;
      ovf_q      <= ovf_nx;
      afr_q      <= afr_base;
      if (take && cnt_nx == CNT_W'(1)) addr_byte <= din;
      if (ev_rme) begin
        end_stat <= stat_byte(afr_base, ovf_nx);
        end_cnt  <= cnt_nx;
      end
    end
  end

  AST_RFS_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rfs |=> cnt_q == CNT_W'(2)); // R4
  AST_POOL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rpf |=> pool_q == '0); // R5
  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rme |=> !in_frame_q); // R8
  AST_STAT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rme |=> $stable(end_stat)); // R9
  AST_OVF_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rdo && !eof_in) |=> in_frame_q); // R7
endmodule

// File: rtl/hrx_irq_reg.sv
module hrx_irq_reg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (clr ? '0 : q) | set;
  end

  AST_SET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((q & $past(set)) == $past(set))); // R10
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> q == '0); // R10
endmodule

// File: rtl/hdlc_rx_event_gen.sv
module hdlc_rx_event_gen
  import hrx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned POOL  = 32,
  parameter int unsigned CNT_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_addr,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       rx_flag_start,
  input  logic       rx_addr_hit,
  input  logic       rx_end,
  input  logic       rd_en,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [3:0] irq_stat
);
  localparam int unsigned NIRQ = $bits(irq_t);

  logic             start_ok, push, fifo_full, fifo_empty, pop, clr;
  logic [7:0]       fifo_dout, addr_byte, end_stat;
  logic [CNT_W-1:0] end_cnt;
  logic [15:0]      cnt_ext;
  irq_t             ev, irq_q;
  logic [NIRQ-1:0]  irq_bits;

  assign start_ok = mode_addr ? rx_addr_hit : rx_flag_start;
  assign pop      = rd_en && rd_addr == 3'(RA_DATA);
  assign clr      = rd_en && rd_addr == 3'(RA_IRQ);
  assign cnt_ext  = 16'(end_cnt);

  hrx_frame_track #(.CNT_W(CNT_W), .POOL(POOL)) u_trk (
    .clk(clk), .rst_n(rst_n), .mode_addr(mode_addr), .start_ok(start_ok),
    .byte_in(rx_valid), .eof_in(rx_end), .din(rx_byte), .fifo_full(fifo_full),
    .push(push), .ev_rfs(ev.rfs), .ev_rpf(ev.rpf), .ev_rme(ev.rme), .ev_rdo(ev.rdo),
    .addr_byte(addr_byte), .end_stat(end_stat), .end_cnt(end_cnt)
  );

  hrx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(rx_byte),
    .dout(fifo_dout), .full(fifo_full), .empty(fifo_empty)
  );

  hrx_irq_reg #(.N(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(ev), .clr(clr), .q(irq_bits)
  );

  assign irq_q    = irq_t'(irq_bits);
  assign irq_stat = irq_bits;

  always_comb begin
    unique case (rd_addr)
      3'(RA_DATA): rd_data = fifo_empty ? 8'h00 : fifo_dout;
      3'(RA_IRQ):  rd_data = 8'(irq_bits);
      3'(RA_STAT): rd_data = end_stat;
      3'(RA_ADDR): rd_data = addr_byte;
      3'(RA_CNTL): rd_data = cnt_ext[7:0];
      3'(RA_CNTH): rd_data = cnt_ext[15:8];
      default:     rd_data = 8'h00;
    endcase
  end

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && fifo_full && (start_ok || $past(1'b1))) && ev.rdo |=> irq_q.rdo); // R6
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push); // R6
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && rd_addr == 3'(RA_DATA)) |-> rd_data == 8'h00); // R2
  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[2:1] == 2'b11) |-> rd_data == 8'h00); // R11
endmodule

// File: tb/hdlc_rx_event_gen_test.sv
module hdlc_rx_event_gen_test;
  localparam int CLK_T = 10;
  localparam int DEPTH = 64;
  localparam int POOL  = 32;

  logic clk = 0, rst_n = 0, mode_addr = 0;
  logic rx_valid = 0, rx_flag_start = 0, rx_addr_hit = 0, rx_end = 0, rd_en = 0;
  logic [7:0] rx_byte = 0;
  logic [2:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [3:0] irq_stat;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  logic [7:0] mq[$];
  logic [3:0] m_irq = 0;
  bit m_in = 0, m_ovf = 0, m_afr = 0;
  int m_cnt = 0, m_pool = 0;
  logic [7:0] m_addr = 0, m_stat = 0;
  int m_ecnt = 0;

  hdlc_rx_event_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_addr(mode_addr), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_flag_start(rx_flag_start), .rx_addr_hit(rx_addr_hit),
    .rx_end(rx_end), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_stat(irq_stat)
  );

  always #(CLK_T/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input int a);
    case (a)
      0: return (mq.size() == 0) ? 8'h00 : mq[0];
      1: return {4'b0, m_irq};
      2: return m_stat;
      3: return m_addr;
      4: return m_ecnt[7:0];
      5: return m_ecnt[15:8];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R2 data";
      1: return "R10 irq";
      2: return "R8 stat";
      3: return "R4 addr";
      4, 5: return "R8 count";
      default: return "R11 spare";
    endcase
  endfunction

  // one clock: drive at negedge, check reads before edge, update model after edge
  task automatic cyc(input bit v, input logic [7:0] d, input bit fs, input bit ah,
                     input bit eo, input bit re, input int ra);
    bit pre_full, st, take;
    logic [3:0] set;
    rx_valid = v; rx_byte = d; rx_flag_start = fs; rx_addr_hit = ah; rx_end = eo;
    rd_en = re; rd_addr = 3'(ra);
    #1;
    chk("R10 irq pins", irq_stat, m_irq);
    if (re) chk(tag_of(ra), rd_data, exp_read(ra));
    @(posedge clk);
    pre_full = (mq.size() == DEPTH);
    if (re && ra == 0 && mq.size() > 0) void'(mq.pop_front());
    if (re && ra == 1) m_irq = 0;
    set = 0;
    st = mode_addr ? ah : fs;
    if (st) begin m_in = 1; m_cnt = 0; m_pool = 0; m_ovf = 0; m_afr = mode_addr; end
    take = v && m_in;
    if (take) begin
      m_cnt++;
      if (m_cnt == 1) m_addr = d;
      if (m_cnt == 2) set[3] = 1;
      if (pre_full) begin set[2] = 1; m_ovf = 1; end
      else begin
        mq.push_back(d);
        m_pool++;
        if (m_pool == POOL) begin set[0] = 1; m_pool = 0; end
      end
    end
    if (eo && m_in) begin
      set[1] = 1; m_stat = {6'b0, m_afr, m_ovf}; m_ecnt = m_cnt; m_in = 0;
    end
    m_irq = m_irq | set;
    @(negedge clk);
    rx_valid = 0; rx_flag_start = 0; rx_addr_hit = 0; rx_end = 0; rd_en = 0;
  endtask

  task automatic rd(input int ra); cyc(0, 0, 0, 0, 0, 1, ra); endtask
  task automatic start_frame(); cyc(0, 0, !mode_addr, mode_addr, 0, 0, 0); endtask
  task automatic put(input logic [7:0] b); cyc(1, b, 0, 0, 0, 0, 0); endtask
  task automatic finish_frame(); cyc(0, 0, 0, 0, 1, 0, 0); endtask
  task automatic drain(); while (mq.size() > 0) rd(0); rd(0); endtask

  initial begin
    #(CLK_T * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] keep;
    void'($urandom(32'h1c3d));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state and R11 spare addresses
    for (int a = 0; a < 8; a++) rd(a);
    chk("R1 irq after reset", irq_stat, 4'h0);

    // R2 byte outside frame ignored
    put(8'hEE); rd(0);
    // R4 transparent start, second byte event
    mode_addr = 0;
    start_frame(); put(8'h5A);
    chk("R4 no start event on first byte", irq_stat[3], 1'b0);
    put(8'hC3);
    chk("R4 start event on second byte", irq_stat[3], 1'b1);
    rd(3); rd(1); put(8'h11); finish_frame();
    rd(2); rd(4); rd(5); rd(1); drain();

    // R3 address mode: opening flag ignored
    mode_addr = 1;
    cyc(0, 0, 1, 0, 0, 0, 0); put(8'h77); put(8'h78); rd(0);
    chk("R3 flag ignored in address mode", irq_stat[3], 1'b0);
    cyc(0, 0, 0, 1, 0, 0, 0); put(8'h81);
    // R10 read on same edge as start event
    cyc(1, 8'h82, 0, 0, 0, 1, 1);
    chk("R10 set kept over clear", irq_stat[3], 1'b1);
    rd(1); finish_frame(); rd(2); rd(1); drain();

    // R5 pools of 32, R6 overflow at 65th, R7 resume after pop
    mode_addr = 0;
    start_frame();
    for (int i = 0; i < 31; i++) put(8'(i));
    chk("R5 no pool event at 31", irq_stat[0], 1'b0);
    put(8'd31);
    chk("R5 pool event at 32", irq_stat[0], 1'b1);
    rd(1);
    for (int i = 32; i < 64; i++) put(8'(i));
    chk("R5 pool re-armed at 64", irq_stat[0], 1'b1);
    put(8'hF0);
    chk("R6 overflow on full", irq_stat[2], 1'b1);
    cyc(1, 8'hF1, 0, 0, 0, 1, 0);
    chk("R6 full judged before pop", irq_stat[2], 1'b1);
    put(8'hF2);
    finish_frame(); rd(2);
    chk("R8 frame status overflow", m_stat, 8'h01);
    rd(4);
    // R9 later frame overflows while earlier status stands
    rd(1); start_frame(); put(8'hA0); put(8'hA1);
    chk("R9 overflow in open frame", irq_stat[2], 1'b1);
    rd(2); finish_frame(); drain();
    keep = 8'h00;
    // R9 clean frame after overflow clears frame flag
    start_frame(); put(8'h01); finish_frame(); rd(2); chk("R9 status follows frame", m_stat, keep);
    drain(); rd(1);

    // random mix
    for (int f = 0; f < 70; f++) begin
      int len;
      mode_addr = $urandom_range(0, 1);
      start_frame();
      len = $urandom_range(0, 90);
      for (int i = 0; i < len; i++) begin
        int r = $urandom_range(0, 9);
        if (r < 3) cyc(1, 8'($urandom), 0, 0, 0, 1, 0);
        else if (r == 3) cyc(1, 8'($urandom), 0, 0, 0, 1, $urandom_range(1, 7));
        else put(8'($urandom));
      end
      if ($urandom_range(0, 3) == 0) cyc(1, 8'($urandom), 0, 0, 1, 0, 0);
      else finish_frame();
      for (int a = 1; a < 6; a++) rd(a);
      if ($urandom_range(0, 2) != 0) drain();
    end
    drain();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule